// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and raises exactly one of three flags: greater, less or equal. It is made of identical narrow slices. Each slice compares its own group of bits and also takes three ordering flags from the slice below it. Inside a slice, those incoming flags only count when the slice's own bits are equal. The slices are chained from the least significant group to the most significant group, and the flags of the top slice are the result. With the default parameters, two 4-bit slices make one 8-bit comparator.

The cascade inputs of the lowest slice are brought out to ports, so the comparator can extend a wider chain that lies outside it. For a standalone compare they are driven as "equal" (equal flag high, the other two low). The comparison logic is purely combinational. For timing and testing it sits between an input register stage and an output register stage, so a result appears two clock edges after its operands are sampled.

Top module: `cascade_cmp`

## Requirements
- R1: When operand A is greater than operand B as an unsigned number, the greater flag is 1 and the less and equal flags are 0, whatever the cascade inputs hold.
- R2: When A is less than B as an unsigned number, the less flag is 1 and the greater and equal flags are 0, whatever the cascade inputs hold.
- R3: When A equals B, the equal flag copies the cascade equal input.
- R4: When A equals B, the greater flag copies the cascade greater input and the less flag copies the cascade less input.
- R5: When exactly one cascade input is 1, exactly one output flag is 1.
- R6: Illegal cascade inputs (more than one of them 1, or none) get no special handling. Every flag follows the rules of R1 to R4, so equal operands pass every raised cascade flag through.
- R7: The flags reflect the operands and cascade inputs that were sampled two rising clock edges earlier. In between, the flags hold their previous value.
- R8: While the active-low reset is 0, all three output flags are 0.
- R9: The most significant slice whose bits differ decides the result. Less significant slices matter only when every slice above them is equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the input and output register stages |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 8 | Operand A, unsigned |
| bIn | input | 8 | Operand B, unsigned |
| gtIn | input | 1 | Cascade greater input from a lower chain |
| ltIn | input | 1 | Cascade less input from a lower chain |
| eqIn | input | 1 | Cascade equal input from a lower chain (1 for a standalone compare) |
| gtOut | output | 1 | A greater than B |
| ltOut | output | 1 | A less than B |
| eqOut | output | 1 | A equal to B |

## Verification
The two functions that act in the same cycle are the local decision of the upper slice and the ordering passed up from the lower slice. Which one wins is set by whether the upper bits are equal. The bench sweeps every one of the 65536 operand pairs with standalone cascade inputs, which covers each case of equal upper nibbles with differing lower nibbles. Every such result is tagged and judged against an integer comparison of the full words. A second pass holds the operands equal or unequal while it walks all eight cascade patterns, so that the pass-through and the override by the local bits are each judged against the flag equations.

// File: rtl/cascade_cmp_pkg.sv
package cascade_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmpFlags_t;

  localparam cmpFlags_t FLAGS_CLEAR = '{gt: 1'b0, lt: 1'b0, eq: 1'b0};

endpackage

// File: rtl/cascade_cmp_slice.sv
module cascade_cmp_slice
  import cascade_cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] aSlice,
  input  logic [SLICE_W-1:0] bSlice,
  input  cmpFlags_t          cascIn,
  output cmpFlags_t          cascOut
);

  logic localGt;
  logic localLt;
  logic localEq;

  // local ordering of this group of bits
  always_comb begin
    localGt = (aSlice > bSlice);
    localLt = (aSlice < bSlice);
    localEq = (aSlice == bSlice);
  end

  // lower-order flags only count when the local bits tie
  always_comb begin
    cascOut.gt = localGt | (localEq & cascIn.gt);
    cascOut.lt = localLt | (localEq & cascIn.lt);
    cascOut.eq = localEq & cascIn.eq;
  end

endmodule

// File: rtl/cascade_cmp_chain.sv
module cascade_cmp_chain
  import cascade_cmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  localparam int DATA_W  = SLICE_W * N_SLICES
) (
  input  logic [DATA_W-1:0] aWord,
  input  logic [DATA_W-1:0] bWord,
  input  cmpFlags_t         chainIn,
  output cmpFlags_t         chainOut
);

  cmpFlags_t link [N_SLICES+1];

  assign link[0] = chainIn;

  // slice 0 holds the least significant bits and feeds upward
  for (genvar s = 0; s < N_SLICES; s++) begin : gSlice
    cascade_cmp_slice #(
      .SLICE_W(SLICE_W)
    ) uSlice (
      .aSlice (aWord[s*SLICE_W +: SLICE_W]),
      .bSlice (bWord[s*SLICE_W +: SLICE_W]),
      .cascIn (link[s]),
      .cascOut(link[s+1])
    );
  end

  assign chainOut = link[N_SLICES];

endmodule

// File: rtl/cascade_cmp.sv
module cascade_cmp
  import cascade_cmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  localparam int DATA_W  = SLICE_W * N_SLICES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              gtIn,
  input  logic              ltIn,
  input  logic              eqIn,
  output logic              gtOut,
  output logic              ltOut,
  output logic              eqOut
);

  logic [DATA_W-1:0] aReg;
  logic [DATA_W-1:0] bReg;
  cmpFlags_t         cascReg;
  cmpFlags_t         cmpComb;
  cmpFlags_t         resReg;

  // input stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      cascReg <= FLAGS_CLEAR;
    end else begin
      aReg    <= aIn;
      bReg    <= bIn;
      cascReg <= '{gt: gtIn, lt: ltIn, eq: eqIn};
    end
  end

  cascade_cmp_chain #(
    .SLICE_W (SLICE_W),
    .N_SLICES(N_SLICES)
  ) uChain (
    .aWord   (aReg),
    .bWord   (bReg),
    .chainIn (cascReg),
    .chainOut(cmpComb)
  );

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resReg <= FLAGS_CLEAR;
    else       resReg <= cmpComb;
  end

  assign gtOut = resReg.gt;
  assign ltOut = resReg.lt;
  assign eqOut = resReg.eq;

endmodule

// File: rtl/cascade_cmp_checker.sv
module cascade_cmp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] bIn,
  input logic              gtIn,
  input logic              ltIn,
  input logic              eqIn,
  input logic              gtOut,
  input logic              ltOut,
  input logic              eqOut
);

  // number of edges seen out of reset, saturating at two
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_greater_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && $past(aIn, 2) > $past(bIn, 2)) |-> (gtOut && !ltOut && !eqOut));

  assert_less_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && $past(aIn, 2) < $past(bIn, 2)) |-> (ltOut && !gtOut && !eqOut));

  assert_equal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && $past(aIn, 2) == $past(bIn, 2)) |-> (eqOut == $past(eqIn, 2)));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && $past(aIn, 2) == $past(bIn, 2))
      |-> (gtOut == $past(gtIn, 2) && ltOut == $past(ltIn, 2)));

  assert_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && $countones({$past(gtIn, 2), $past(ltIn, 2), $past(eqIn, 2)}) == 1)
      |-> ($countones({gtOut, ltOut, eqOut}) == 1));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_clear_R8: assert ({gtOut, ltOut, eqOut} == 3'b000);
    end
  end

endmodule

bind cascade_cmp cascade_cmp_checker #(.DATA_W(DATA_W)) u_checker (
  .clk  (clk),
  .rstN (rstN),
  .aIn  (aIn),
  .bIn  (bIn),
  .gtIn (gtIn),
  .ltIn (ltIn),
  .eqIn (eqIn),
  .gtOut(gtOut),
  .ltOut(ltOut),
  .eqOut(eqOut)
);

// File: tb/cascade_cmp_bench.sv
`timescale 1ns/1ps
module cascade_cmp_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] aIn = '0;
  logic [7:0] bIn = '0;
  logic       gtIn = 1'b0;
  logic       ltIn = 1'b0;
  logic       eqIn = 1'b1;
  logic       gtOut, ltOut, eqOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [2:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  cascade_cmp u_cascade_cmp (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .gtIn(gtIn), .ltIn(ltIn), .eqIn(eqIn),
    .gtOut(gtOut), .ltOut(ltOut), .eqOut(eqOut)
  );

  // flags packed as {gt, lt, eq}
  function automatic logic [2:0] refFlags(int a, int b, logic g, logic l, logic e);
    if (a > b)      return 3'b100;
    else if (a < b) return 3'b010;
    else            return {g, l, e};
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flags {gt,lt,eq} actual %b expected %b", req, act, exp);
    end
  endtask

  // one cycle: judge the result due now, then drive new inputs
  task automatic step(int a, int b, logic g, logic l, logic e, string req);
    @(negedge clk);
    if (expQ.size() == 2) begin
      logic [2:0] ex;
      string t;
      ex = expQ.pop_front();
      t  = tagQ.pop_front();
      check(t, {gtOut, ltOut, eqOut}, ex);
      if ($countones({g, l, e}) == 1) check("R5", 3'($countones({gtOut, ltOut, eqOut})), 3'd1);
    end
    aIn = 8'(a); bIn = 8'(b); gtIn = g; ltIn = l; eqIn = e;
    expQ.push_back(refFlags(a, b, g, l, e));
    tagQ.push_back(req);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state, with inputs that would otherwise give gt
    aIn = 8'hF0; bIn = 8'h0F;
    repeat (3) @(negedge clk);
    check("R8", {gtOut, ltOut, eqOut}, 3'b000);

    // R7: latency of two edges
    @(negedge clk);
    rstN = 1'b1;
    aIn = 8'h33; bIn = 8'h33; gtIn = 0; ltIn = 0; eqIn = 1;
    repeat (3) @(negedge clk);
    check("R7", {gtOut, ltOut, eqOut}, 3'b001);
    aIn = 8'h34;
    @(negedge clk);
    check("R7", {gtOut, ltOut, eqOut}, 3'b001);
    @(negedge clk);
    check("R7", {gtOut, ltOut, eqOut}, 3'b100);

    // full sweep with standalone cascade inputs
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        string t;
        if ((a >> 4) == (b >> 4) && a != b) t = "R9";
        else if (a > b) t = "R1";
        else if (a < b) t = "R2";
        else t = "R3";
        step(a, b, 1'b0, 1'b0, 1'b1, t);
      end
    end

    // every cascade pattern, legal and illegal, against tie and non-tie operands
    for (int c = 0; c < 8; c++) begin
      logic g, l, e;
      string t;
      {g, l, e} = 3'(c);
      t = ($countones(3'(c)) == 1) ? "R4" : "R6";
      step(8'h5A, 8'h5A, g, l, e, t);
      step(8'h00, 8'h00, g, l, e, t);
      step(8'hFF, 8'hFF, g, l, e, t);
      step(8'h81, 8'h80, g, l, e, "R1");
      step(8'h0F, 8'h10, g, l, e, "R2");
      step(8'h2C, 8'h2B, g, l, e, "R9");
    end

    // drain the pipeline
    step(0, 0, 1'b0, 1'b0, 1'b1, "R3");
    step(0, 0, 1'b0, 1'b0, 1'b1, "R3");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule